// File: doc/BRIEF.md
# Sparse-Decode One-Second Divider

This block divides a fixed reference clock down to a once-per-second time base. A 24-bit binary up-counter runs from the reference clock. Terminal count is not found by a full equality compare. Instead, the block ANDs together only those counter bits that are ones in the terminal constant. Because the counter climbs from zero, the first value that sets all of those bits is the constant itself.

When the decode fires, a stretched clear holds the counter at zero for a programmable number of reference cycles, so every period grows by that number of cycles. A compile-time option pulls the threshold down by the same amount, which restores the exact period. When the divisor is a power of two, the block builds no decode and no clear logic. The counter runs freely and one of its bits is tapped as the output.

The outputs are a single-cycle tick, a square wave that changes state once per period, and the live count. An enable freezes all internal state.

Top module: `sparse_pps_divider`

## Requirements
- R1: While rst_n is low, count, tick and sq_out are all 0.
- R2: In decoded mode the threshold T is DIVISOR, or DIVISOR-RESET_CYCLES when COMPENSATE is 1. The decode uses only the one-bits of T, and tick is never 1 while count is below T.
- R3: After a tick in decoded mode, count reads 0 for exactly RESET_CYCLES enabled cycles, then continues at 1.
- R4: In decoded mode without compensation, successive ticks are DIVISOR+RESET_CYCLES enabled cycles apart.
- R5: With COMPENSATE=1, successive ticks are exactly DIVISOR enabled cycles apart.
- R6: When DIVISOR is a power of two, count runs freely without a clear. Ticks fall on count values that are multiples of DIVISOR. sq_out equals count bit log2(DIVISOR)-1.
- R7: tick is high for exactly one cycle per period and is 0 whenever en is 0.
- R8: In decoded mode sq_out starts at 0 and inverts in the cycle after each tick.
- R9: While en is 0, count, the clear-window timer and sq_out hold their values. A tick that was due is delayed until en returns to 1.
- R10: After reset is released with en high, count is 0 in the first cycle and increases by one per cycle. The first tick appears with count equal to T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Count enable; low freezes all state |
| tick | output | 1 | One-cycle pulse once per period |
| sq_out | output | 1 | Square-wave time base |
| count | output | CNT_W | Running counter value |

## Verification
The bench builds three copies of the block. The first uses divisor 50 with a 3-cycle clear and no compensation. The second uses divisor 100 with a 7-cycle clear and compensation, which gives threshold 93 and an odd, sparse mask. The third uses divisor 64, which selects the power-of-two tap. These small divisors keep every period within a few hundred cycles, so each copy can be checked across several whole periods against an independent count model. The cases covered are: ticks at the exact threshold and never before it, zero inside each clear window, tick spacing, and the enable freeze both on the threshold cycle and inside a clear window.

// File: rtl/pps_div_pkg.sv
`timescale 1ns/1ps
package pps_div_pkg;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int floor_log2(input int unsigned v);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/pps_counter.sv
`timescale 1ns/1ps
module pps_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (clr) cnt_d = '0;
      else     cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/pps_hold_timer.sv
`timescale 1ns/1ps
module pps_hold_timer #(
  parameter int CYCLES = 7,
  localparam int LW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  output logic active,
  output logic last
);

  logic          act_q, act_d;
  logic [LW-1:0] left_q, left_d;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    if (en) begin
      if (start) begin
        act_d  = 1'b1;
        left_d = LW'(CYCLES - 1);
      end else if (act_q) begin
        if (left_q == '0) act_d = 1'b0;
        else              left_d = left_q - LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
    end
  end

  assign active = act_q;
  assign last   = act_q && (left_q == '0);

  // R3
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start) |=> active);

  // R9
  win_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(active));

endmodule

// File: rtl/pps_mask_decode.sv
`timescale 1ns/1ps
module pps_mask_decode #(
  parameter int           W    = 24,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic [W-1:0] count,
  output logic         hit
);

  logic [W-1:0] term;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_used
      assign term[i] = count[i];
    end else begin : g_skip
      assign term[i] = 1'b1;
    end
  end

  assign hit = &term;

endmodule

// File: rtl/sparse_pps_divider.sv
`timescale 1ns/1ps
module sparse_pps_divider
  import pps_div_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int DIVISOR      = 50000,
  parameter int RESET_CYCLES = 7,
  parameter bit COMPENSATE   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic             tick,
  output logic             sq_out,
  output logic [CNT_W-1:0] count
);

  localparam bit   POW2    = is_pow2(DIVISOR);
  localparam int   THRESH  = COMPENSATE ? (DIVISOR - RESET_CYCLES) : DIVISOR;
  localparam int   TAP_RAW = floor_log2(DIVISOR) - 1;
  localparam int   TAP     = (TAP_RAW > 0) ? TAP_RAW : 0;
  localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] LOWMASK  = CNT_W'(DIVISOR - 1);

  logic clr;

  pps_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .clr   (clr),
    .count (count)
  );

  if (POW2) begin : g_pow2
    logic tap_q, tap_d;

    assign clr = 1'b0;

    always_comb begin
      tap_d = en ? count[TAP] : tap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q <= 1'b0;
      else        tap_q <= tap_d;
    end

    assign tick   = en && tap_q && !count[TAP];
    assign sq_out = count[TAP];

    // R6
    pow2_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> ((count & LOWMASK) == '0));

  end else begin : g_dec
    logic hit, active, last, fire;
    logic sq_q, sq_d;

    pps_mask_decode #(.W(CNT_W), .MASK(THRESH_V)) u_dec (
      .count (count),
      .hit   (hit)
    );

    pps_hold_timer #(.CYCLES(RESET_CYCLES)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .start  (fire),
      .active (active),
      .last   (last)
    );

    assign fire = en && hit && !active;
    assign clr  = fire || (active && !last);

    always_comb begin
      sq_d = fire ? ~sq_q : sq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq_q <= 1'b0;
      else        sq_q <= sq_d;
    end

    assign tick   = fire;
    assign sq_out = sq_q;

    // R3
    win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (count == '0));

    // R2
    first_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !active) |-> (count == THRESH_V));

    // R8
    sq_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (sq_out != $past(sq_out)));
  end

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R9
  en_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(count) && $stable(sq_out)));

endmodule

// File: tb/sim_sparse_pps_divider.sv
`timescale 1ns/1ps
module sim_sparse_pps_divider;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        en   [3];
  logic        tk   [3];
  logic        sq   [3];
  logic [23:0] cnt  [3];

  int checks = 0;
  int errors = 0;

  sparse_pps_divider #(.CNT_W(24), .DIVISOR(50), .RESET_CYCLES(3), .COMPENSATE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en[0]), .tick(tk[0]), .sq_out(sq[0]), .count(cnt[0]));
  sparse_pps_divider #(.CNT_W(24), .DIVISOR(100), .RESET_CYCLES(7), .COMPENSATE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en[1]), .tick(tk[1]), .sq_out(sq[1]), .count(cnt[1]));
  sparse_pps_divider #(.CNT_W(24), .DIVISOR(64), .RESET_CYCLES(3), .COMPENSATE(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .en(en[2]), .tick(tk[2]), .sq_out(sq[2]), .count(cnt[2]));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  function automatic longint dec_cnt(longint n, longint t, longint r);
    longint m;
    if (n <= t) return n;
    m = (n - t) % (t + r);
    if (m == 0) return t;
    if (m <= r) return 0;
    return m - r;
  endfunction

  function automatic bit dec_tick(longint n, longint t, longint r);
    return (n >= t) && (((n - t) % (t + r)) == 0);
  endfunction

  function automatic bit dec_sq(longint n, longint t, longint r);
    if (n <= t) return 1'b0;
    return 1'(((n - t - 1) / (t + r)) + 1);
  endfunction

  // Reset all copies, then release with only copy id enabled. R1 and R10 start state.
  task automatic do_reset(input int id);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) en[i] = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    for (int i = 0; i < 3; i++) begin
      chk("R1 count", cnt[i], 0);
      chk("R1 tick", tk[i], 0);
      chk("R1 sq_out", sq[i], 0);
    end
    @(negedge clk);
    rst_n  = 1'b1;
    en[id] = 1'b1;
    #1;
    chk("R10 count at release", cnt[id], 0);
  endtask

  task automatic run_decoded(input int id, input longint t, input longint r,
                             input longint period, input int cycles,
                             input longint pa, input longint pb, input int plen,
                             input string tag);
    longint n = 0;
    longint last_tk = -1;
    int held = 0;
    bit en_prev = 1'b1;
    do_reset(id);
    while (n < cycles) begin
      @(negedge clk);
      if (en_prev) begin
        n++;
        held = 0;
      end
      if ((n == pa || n == pb) && held < plen) begin
        en[id] = 1'b0;
        held++;
      end else begin
        en[id] = 1'b1;
      end
      #1;
      chk({tag, " R2/R3 count"}, cnt[id], dec_cnt(n, t, r));
      chk({tag, " R7/R9 tick"}, tk[id], en[id] && dec_tick(n, t, r));
      chk({tag, " R8 sq_out"}, sq[id], dec_sq(n, t, r));
      if (tk[id]) begin
        if (last_tk < 0) chk({tag, " R10 first tick"}, n, t);
        else             chk({tag, " R4/R5 spacing"}, n - last_tk, period);
        last_tk = n;
      end
      en_prev = en[id];
    end
    en[id] = 1'b0;
  endtask

  task automatic run_pow2(input int cycles, input longint pa, input int plen);
    longint n = 0;
    longint last_tk = -1;
    int held = 0;
    bit en_prev = 1'b1;
    do_reset(2);
    while (n < cycles) begin
      @(negedge clk);
      if (en_prev) begin
        n++;
        held = 0;
      end
      if (n == pa && held < plen) begin
        en[2] = 1'b0;
        held++;
      end else begin
        en[2] = 1'b1;
      end
      #1;
      chk("R6 count free-running", cnt[2], n);
      chk("R6/R7 tick", tk[2], en[2] && n > 0 && (n % 64) == 0);
      chk("R6 sq_out tap", sq[2], (n >> 5) & 1);
      if (tk[2]) begin
        if (last_tk >= 0) chk("R6 spacing", n - last_tk, 64);
        last_tk = n;
      end
      en_prev = en[2];
    end
    en[2] = 1'b0;
  endtask

  // R2 R3 R4 R7 R8 R10: plain decode, threshold 50, 3-cycle clear.
  task automatic t_plain();
    run_decoded(0, 50, 3, 53, 50 + 3 * 53, -1, -1, 0, "plain");
  endtask

  // R5: compensated, threshold 93 (sparse mask), period exactly 100.
  task automatic t_compensated();
    run_decoded(1, 93, 7, 100, 93 + 3 * 100 + 5, -1, -1, 0, "comp");
  endtask

  // R6: power-of-two tap.
  task automatic t_pow2();
    run_pow2(64 * 4 + 3, -1, 0);
  endtask

  // R9: enable low on the threshold cycle and inside a clear window.
  task automatic t_enable();
    run_decoded(0, 50, 3, 53, 50 + 2 * 53, 50, 52, 4, "enable");
    run_pow2(64 * 2 + 2, 64, 5);
  endtask

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) en[i] = 1'b0;
    t_plain();
    t_compensated();
    t_pow2();
    t_enable();
    report();
    $finish;
  end

endmodule